// File: doc/BRIEF.md
# Host-to-MCU Command Handshake Flag and MCU Reset Control

This block sits between a parallel host bus and a small microcontroller that talks to the card over a serial link it drives itself. Each time the host writes the outgoing data register, a command-waiting flag is raised. The flag goes straight to the microcontroller as an interrupt request. The microcontroller pulls an active-low clear line when it has finished with the command, and the flag drops. The host polls a second copy of the flag, which is re-registered on the rising bus clock edge so that the value it reads never moves mid-cycle.

Bus writes are taken on the falling clock edge, the point where write data is valid. The host also writes bit 0 of its data through the upper (ROM) address window, and the inverse of that bit drives the microcontroller's active-low reset pin. Only this control bit responds to system reset. The flag, its bus-side copy and the clear synchronizer keep their state through a system reset.

Top module: `cmd_pend_ctl`

## Requirements
- R1: `reg_wr` high at a falling `clk` edge sets the flag, and `mcu_irq` is 1 from that edge on.
- R2: `host_pend` changes only at rising `clk` edges, and at each one it takes the value `mcu_irq` had just before that edge. A newly set flag therefore reaches `host_pend` half a cycle after it reaches `mcu_irq`.
- R3: `clr_n` passes through two falling-edge synchronizer flops. If `clr_n` is low at falling edge k, the flag clears at falling edge k+2, provided there is no write at that edge. A single-cycle low pulse is enough to clear the flag.
- R4: When a write and a synchronized clear meet at the same falling edge, the write wins and the flag is 1 after that edge.
- R5: While `clr_n` stays high, a set flag stays at 1 and keeps `mcu_irq` and `host_pend` at 1.
- R6: `rom_wr` high at a falling edge loads `rom_wd0` into the control bit, and `mcu_rst_n` equals the inverse of the control bit. Writing 1 puts the microcontroller in reset (pin 0), and writing 0 releases it (pin 1).
- R7: Without `rom_wr`, the control bit holds its value. `rom_wd0` changes and `reg_wr` writes leave `mcu_rst_n` unchanged.
- R8: `rst_n` low clears the control bit at once, without waiting for a clock edge, so `mcu_rst_n` is 1.
- R9: `rst_n` has no effect on the flag or on its bus-side copy. A set flag is still 1 on `mcu_irq` and `host_pend` during and after a system reset.
- R10: `rom_wr` never sets the flag. With the flag clear, a ROM-window write leaves `mcu_irq` and `host_pend` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock. Writes are taken on the falling edge; the host status copy is taken on the rising edge. |
| rst_n | input | 1 | Active-low system reset. It acts only on the control bit. |
| reg_wr | input | 1 | Strobe for a host write to the outgoing data register. |
| clr_n | input | 1 | Active-low clear from the microcontroller; asynchronous to the bus. |
| rom_wr | input | 1 | Strobe for a host write to the ROM address window. |
| rom_wd0 | input | 1 | Bit 0 of the host write data. |
| mcu_irq | output | 1 | Command-waiting interrupt request to the microcontroller (active high). |
| host_pend | output | 1 | Status bit for the host, read alongside the ROM byte lane. |
| mcu_rst_n | output | 1 | Active-low reset pin of the microcontroller. |

## Verification
The flag is exercised four ways: a lone write, observed both half a cycle and a full cycle later, which separates the interrupt path from the lagging host copy; a clear of one cycle, checked cycle by cycle, which confirms the two-stage delay and that a short pulse is enough; a write landing on a clear held low, which shows whether the write wins or the clear wins; and a long hold with the clear high, which catches any spontaneous decay. The control bit is driven with writes of both values and with data changes that come without a strobe. A system reset is applied while both the flag and the control bit are set, which separates the one register that resets from the ones that must not.

// File: rtl/cmd_pend_ctl.sv
module cmd_pend_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_wr,
  input  logic clr_n,
  input  logic rom_wr,
  input  logic rom_wd0,
  output logic mcu_irq,
  output logic host_pend,
  output logic mcu_rst_n
);

  logic [1:0] clr_sync;
  logic       clr_req;
  logic       pend_q;
  logic       host_q;
  logic       ctl_q;

  always_ff @(negedge clk)
    clr_sync <= {clr_sync[0], clr_n};

  assign clr_req = ~clr_sync[1];

  always_ff @(negedge clk)
    if (reg_wr)       pend_q <= 1'b1;
    else if (clr_req) pend_q <= 1'b0;

  always_ff @(posedge clk)
    host_q <= pend_q;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= 1'b0;
    else if (rom_wr) ctl_q <= rom_wd0;

  assign mcu_irq   = pend_q;
  assign host_pend = host_q;
  assign mcu_rst_n = ~ctl_q;

endmodule

// File: rtl/cmd_pend_ctl_chk.sv
module cmd_pend_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_wr,
  input logic clr_n,
  input logic rom_wr,
  input logic rom_wd0,
  input logic mcu_irq,
  input logic host_pend,
  input logic mcu_rst_n
);

  p_set_r1: assert property (@(negedge clk) disable iff (!rst_n)
    $past(reg_wr) |-> mcu_irq);

  p_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_pend == $past(mcu_irq));

  p_clear_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (!$past(clr_n, 3) && !$past(reg_wr)) |-> !mcu_irq);

  p_setwins_r4: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(reg_wr) && !$past(clr_n, 3)) |-> mcu_irq);

  p_ctl_load_r6: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(rom_wr) && $past(rst_n)) |-> (mcu_rst_n == !$past(rom_wd0)));

  p_ctl_hold_r7: assert property (@(negedge clk) disable iff (!rst_n)
    (!$past(rom_wr) && $past(rst_n)) |-> $stable(mcu_rst_n));

  p_sysrst_r8: assert property (@(posedge clk)
    !rst_n |-> mcu_rst_n);

  p_norise_r10: assert property (@(negedge clk) disable iff (!rst_n)
    (!$past(reg_wr) && !$past(mcu_irq)) |-> !mcu_irq);

endmodule

bind cmd_pend_ctl cmd_pend_ctl_chk u_chk (.*);

// File: tb/cmd_pend_ctl_bench.sv
module cmd_pend_ctl_bench;

  logic clk = 1'b1;
  logic rst_n = 1'b1;
  logic reg_wr = 1'b0;
  logic clr_n = 1'b1;
  logic rom_wr = 1'b0;
  logic rom_wd0 = 1'b0;
  logic mcu_irq, host_pend, mcu_rst_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmd_pend_ctl u_cmd_pend_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .clr_n(clr_n),
    .rom_wr(rom_wr), .rom_wd0(rom_wd0),
    .mcu_irq(mcu_irq), .host_pend(host_pend), .mcu_rst_n(mcu_rst_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic flush_flag();
    clr_n = 1'b0;
    repeat (3) tick();
    clr_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic t_reset();
    #1 rst_n = 1'b0;
    tick();
    chk("R8", "mcu_rst_n in reset", mcu_rst_n, 1'b1);
    tick();
    rst_n = 1'b1;
    flush_flag();
    chk("R3", "flag after flush", mcu_irq, 1'b0);
    chk("R2", "host copy after flush", host_pend, 1'b0);
  endtask

  task automatic t_set();
    reg_wr = 1'b1;
    @(negedge clk); #2;
    chk("R1", "irq half cycle after write", mcu_irq, 1'b1);
    chk("R2", "host copy lags", host_pend, 1'b0);
    @(posedge clk); #1;
    reg_wr = 1'b0;
    chk("R1", "irq after write", mcu_irq, 1'b1);
    chk("R2", "host copy after rising edge", host_pend, 1'b1);
  endtask

  task automatic t_clear();
    clr_n = 1'b0;
    tick();
    clr_n = 1'b1;
    chk("R3", "irq one cycle into clear", mcu_irq, 1'b1);
    tick();
    chk("R3", "irq two cycles into clear", mcu_irq, 1'b1);
    chk("R3", "host copy two cycles into clear", host_pend, 1'b1);
    tick();
    chk("R3", "irq cleared by short pulse", mcu_irq, 1'b0);
    chk("R3", "host copy cleared", host_pend, 1'b0);
    repeat (2) tick();
  endtask

  task automatic t_setwins();
    clr_n = 1'b0;
    repeat (3) tick();
    reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    chk("R4", "write beats held clear", mcu_irq, 1'b1);
    chk("R4", "host copy sees write", host_pend, 1'b1);
    tick();
    chk("R4", "held clear acts next edge", mcu_irq, 1'b0);
    clr_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic t_hold();
    reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick();
      chk("R5", "flag holds", mcu_irq, 1'b1);
    end
    chk("R5", "host copy holds", host_pend, 1'b1);
  endtask

  task automatic t_ctl();
    rom_wr = 1'b1; rom_wd0 = 1'b1;
    tick();
    chk("R6", "write 1 asserts pin", mcu_rst_n, 1'b0);
    rom_wd0 = 1'b0; rom_wr = 1'b0;
    tick();
    chk("R7", "data without strobe", mcu_rst_n, 1'b0);
    reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    chk("R7", "data-register write ignored", mcu_rst_n, 1'b0);
    rom_wd0 = 1'b1;
    tick();
    chk("R7", "still held", mcu_rst_n, 1'b0);
  endtask

  task automatic t_sysreset();
    rst_n = 1'b0;
    #1;
    chk("R8", "async clear of control", mcu_rst_n, 1'b1);
    repeat (2) tick();
    chk("R9", "flag survives reset", mcu_irq, 1'b1);
    chk("R9", "host copy survives reset", host_pend, 1'b1);
    rst_n = 1'b1;
    tick();
    chk("R9", "flag after reset", mcu_irq, 1'b1);
  endtask

  task automatic t_romwr_noflag();
    flush_flag();
    rom_wr = 1'b1; rom_wd0 = 1'b0;
    tick();
    rom_wr = 1'b0;
    chk("R6", "write 0 releases pin", mcu_rst_n, 1'b1);
    tick();
    chk("R10", "rom write leaves irq", mcu_irq, 1'b0);
    chk("R10", "rom write leaves host copy", host_pend, 1'b0);
  endtask

  initial begin
    t_reset();
    t_set();
    t_clear();
    t_setwins();
    t_hold();
    t_ctl();
    t_sysreset();
    t_romwr_noflag();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule